// File: doc/BRIEF.md
# I2C Interrupt Status Controller

This block keeps the event side of an I2C master controller: a status word that collects one-cycle event pulses from the transfer engine, an enable mask, an interrupt vector that software reads, and the routing of the two ready flags onto DMA request lines. It drives one level-sensitive interrupt and two DMA requests, all registered. A live bus-busy input is folded into the status readback.

Software reaches the block over a small register port with four word selects: status at select 0, enable mask at select 1, vector at select 2 and DMA configuration at select 3. Reads return data combinationally in the cycle the read strobe is high. Side effects of a read or write, such as a vector read acknowledging its source, take effect at the clock edge that ends the access. The transfer engine drops the receive-ready and transmit-ready flags through its own clear strobes. A status write cannot clear those two flags.

Top module: `i2c_irq_ctl`

## Requirements
- R1: After reset the status, mask and DMA configuration read as zero, and `irq_o` and `drq_o` are low.
- R2: A pulse on `evt_i` sets one status bit. The bit positions are: evt 0 sets bit 1 (no-acknowledge), evt 1 sets bit 2 (access ready), evt 2 sets bit 3 (receive ready), evt 3 sets bit 4 (transmit ready), evt 4 sets bit 10 (transmit underflow), evt 5 sets bit 11 (receive overrun) and evt 6 sets bit 15 (single byte data).
- R3: Status bit 12 reads back the live level of `busy_i`.
- R4: A write to the status select clears the status bits that are set in both the written value and 0x0027. No other bit is changed by such a write.
- R5: `rdy_clr_i[0]` clears status bit 3, and `rdy_clr_i[1]` clears status bit 4.
- R6: An event pulse in the same cycle as any clear of its bit leaves the bit set.
- R7: The mask keeps write data bits 5:0 when NEW_REV=1, or bits 4:0 when NEW_REV=0. All other bits read back as zero.
- R8: `irq_o` is high one clock after (status AND mask) is nonzero, and low one clock after it is zero.
- R9: A vector read returns 1 + the index of the lowest set bit of (status[5:0] AND mask). It returns 0 when no such bit is set. The access clears that status bit.
- R10: The DMA configuration keeps only write data bits 15 (receive enable) and 7 (transmit enable). Writing bit 15 as 1 clears mask bit 3. Writing bit 7 as 1 clears mask bit 4.
- R11: One clock after a change, `drq_o[0]` equals (receive enable AND status bit 3), and `drq_o[1]` equals (transmit enable AND status bit 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| evt_i | input | 7 | Event pulses from the transfer engine |
| rdy_clr_i | input | 2 | Hardware clear of receive/transmit ready |
| busy_i | input | 1 | Live bus-busy level |
| irq_o | output | 1 | Level interrupt |
| drq_o | output | 2 | DMA requests (0 receive, 1 transmit) |

## Verification
An event pulse and a clear of the same status bit can fall in one cycle. The clear can come from a status write, a ready-flag clear strobe or a vector acknowledge. The bench drives each of these clears on the same clock edge as the matching event and then reads the status back, expecting the bit still set. The vector path is swept over every mask value and every combination of the four low event flags. Each vector, the following status readback and the interrupt level are compared with values computed from the lowest-set-bit rule.

// File: rtl/i2c_irq_ctl.sv
module i2c_irq_ctl #(
  parameter bit NEW_REV = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [1:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic [6:0]  evt_i,
  input  logic [1:0]  rdy_clr_i,
  input  logic        busy_i,
  output logic        irq_o,
  output logic [1:0]  drq_o
);
  localparam logic [1:0] SEL_STAT = 2'd0, SEL_MASK = 2'd1, SEL_VEC = 2'd2, SEL_DMA = 2'd3;
  localparam logic [5:0]  MASK_KEEP = NEW_REV ? 6'h3f : 6'h1f;
  localparam logic [15:0] W1C_BITS  = 16'h0027;

  logic [15:0] stat_q, stat_d, ev_set, clr;
  logic [5:0]  mask_q, mask_d, pend, low;
  logic        dma_rx_q, dma_tx_q;
  logic [2:0]  vec_idx;

  wire wr_stat = wr_i && addr_i == SEL_STAT;
  wire wr_mask = wr_i && addr_i == SEL_MASK;
  wire wr_dma  = wr_i && addr_i == SEL_DMA;
  wire rd_vec  = rd_i && addr_i == SEL_VEC;

  assign ev_set = {evt_i[6], 3'b000, evt_i[5], evt_i[4], 5'b00000,
                   evt_i[3], evt_i[2], evt_i[1], evt_i[0], 1'b0};

  assign pend = stat_q[5:0] & mask_q;
  assign low  = pend & (~pend + 6'd1);

  always_comb begin
    vec_idx = 3'd0;
    for (int i = 5; i >= 0; i--)
      if (pend[i]) vec_idx = 3'(i + 1);
  end

  assign clr = (wr_stat ? (wdata_i & W1C_BITS) : 16'h0)
             | (rd_vec ? {10'h0, low} : 16'h0)
             | {11'h0, rdy_clr_i[1], rdy_clr_i[0], 3'b000};

  assign stat_d = (stat_q & ~clr) | ev_set;

  always_comb begin
    mask_d = mask_q;
    if (wr_mask) mask_d = wdata_i[5:0] & MASK_KEEP;
    if (wr_dma)  mask_d = mask_q & ~{1'b0, wdata_i[7], wdata_i[15], 3'b000};
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stat_q   <= '0;
      mask_q   <= '0;
      dma_rx_q <= 1'b0;
      dma_tx_q <= 1'b0;
      irq_o    <= 1'b0;
      drq_o    <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      if (wr_dma) begin
        dma_rx_q <= wdata_i[15];
        dma_tx_q <= wdata_i[7];
      end
      irq_o <= |pend;
      drq_o <= {dma_tx_q & stat_q[4], dma_rx_q & stat_q[3]};
    end
  end

  always_comb begin
    unique case (addr_i)
      SEL_STAT: rdata_o = stat_q | {3'b000, busy_i, 12'h000};
      SEL_MASK: rdata_o = {10'h0, mask_q};
      SEL_VEC:  rdata_o = {13'h0, vec_idx};
      default:  rdata_o = {dma_rx_q, 7'h0, dma_tx_q, 7'h0};
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[14:8], wdata_i[6]};

  // R6
  nack_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[0] |=> stat_q[1]);
  // R4
  ardy_wclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[2] && !evt_i[1]) |=> !stat_q[2]);
  // R8
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_q[5:0] & mask_q)) |=> irq_o);
  // R10
  rx_dma_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dma && wdata_i[15]) |=> !mask_q[3]);
  // R11
  drq_rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_rx_q |=> !drq_o[0]);
  // R9
  vec_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec && vec_idx == 3'd2 && !evt_i[0]) |=> !stat_q[1]);
endmodule

// File: tb/sim_i2c_irq_ctl.sv
module sim_i2c_irq_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, busy = 1'b0;
  logic [1:0] addr = '0, rclr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [6:0] evt = '0;
  logic irq;
  logic [1:0] drq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_irq_ctl #(.NEW_REV(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .rdy_clr_i(rclr),
    .busy_i(busy), .irq_o(irq), .drq_o(drq));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wreg(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(logic [6:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  function automatic int exp_vec(int pendv);
    for (int b = 0; b < 6; b++) if (pendv[b]) return b + 1;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    static int pos[7] = '{1, 2, 3, 4, 10, 11, 15};
    do_reset();
    // R1
    chk("R1 irq", int'(irq), 0); chk("R1 drq", int'(drq), 0);
    rreg(2'd0, d); chk("R1 stat", d, 0);
    rreg(2'd1, d); chk("R1 mask", d, 0);
    rreg(2'd3, d); chk("R1 dma", d, 0);

    // R2 and R4: each event sets its bit, a status write clears only 0x27 bits
    for (int i = 0; i < 7; i++) begin
      do_reset();
      pulse(7'(1 << i));
      rreg(2'd0, d); chk("R2 set", d, 1 << pos[i]);
      wreg(2'd0, 16'hffff);
      rreg(2'd0, d); chk("R4 wclr", d, ((1 << pos[i]) & 16'h0027) != 0 ? 0 : (1 << pos[i]));
    end

    // R3
    busy = 1'b1; rreg(2'd0, d); chk("R3 busy1", int'(d[12]), 1);
    busy = 1'b0; rreg(2'd0, d); chk("R3 busy0", int'(d[12]), 0);

    // R5
    do_reset(); pulse(7'b0001100);
    @(negedge clk); rclr = 2'b01; @(negedge clk); rclr = 2'b00;
    rreg(2'd0, d); chk("R5 rrdy clr", d, 16'h0010);
    @(negedge clk); rclr = 2'b10; @(negedge clk); rclr = 2'b00;
    rreg(2'd0, d); chk("R5 xrdy clr", d, 16'h0000);

    // R6: event coincides with write clear, hw clear, vector ack
    do_reset();
    @(negedge clk); wr = 1'b1; addr = 2'd0; wdata = 16'h0006; evt = 7'b0000011;
    @(negedge clk); wr = 1'b0; wdata = '0; evt = '0;
    rreg(2'd0, d); chk("R6 vs write", d, 16'h0006);
    @(negedge clk); rclr = 2'b01; evt = 7'b0000100;
    @(negedge clk); rclr = 2'b00; evt = '0;
    rreg(2'd0, d); chk("R6 vs hwclr", int'(d[3]), 1);
    wreg(2'd1, 16'h0002);
    @(negedge clk); rd = 1'b1; addr = 2'd2; evt = 7'b0000001;
    @(negedge clk); rd = 1'b0; evt = '0;
    rreg(2'd0, d); chk("R6 vs vector", int'(d[1]), 1);

    // R7
    do_reset();
    for (int v = 0; v < 256; v += 3) begin
      wreg(2'd1, 16'(v) | 16'hff00);
      rreg(2'd1, d); chk("R7 mask", d, v & 16'h3f);
    end

    // R8, R9 sweep
    for (int m = 0; m < 64; m++) begin
      for (int s = 0; s < 16; s++) begin
        int st, pv, ev;
        do_reset();
        wreg(2'd1, 16'(m));
        pulse(7'(s));
        st = s << 1; pv = st & m; ev = exp_vec(pv);
        @(negedge clk);
        chk("R8 irq", int'(irq), pv != 0 ? 1 : 0);
        rreg(2'd2, d); chk("R9 vec", d, ev);
        rreg(2'd0, d); chk("R9 ack", d, ev == 0 ? st : (st & ~(1 << (ev - 1))));
      end
    end
    do_reset(); wreg(2'd1, 16'h0002); pulse(7'b0000001);
    wreg(2'd0, 16'h0002); @(negedge clk);
    chk("R8 irq low", int'(irq), 0);

    // R10, R11
    do_reset();
    wreg(2'd1, 16'h001f);
    wreg(2'd3, 16'hffff);
    rreg(2'd3, d); chk("R10 dma keep", d, 16'h8080);
    rreg(2'd1, d); chk("R10 mask cut", d, 16'h0007);
    pulse(7'b0000100); @(negedge clk);
    chk("R11 drq0 on", int'(drq), 1); chk("R10 irq masked", int'(irq), 0);
    @(negedge clk); rclr = 2'b01; @(negedge clk); rclr = 2'b00; @(negedge clk);
    chk("R11 drq0 off", int'(drq), 0);
    pulse(7'b0001000); @(negedge clk);
    chk("R11 drq1 on", int'(drq), 2);
    wreg(2'd3, 16'h0000); @(negedge clk);
    chk("R11 tx disabled", int'(drq), 0);
    wreg(2'd1, 16'h001f); wreg(2'd3, 16'h0080);
    rreg(2'd1, d); chk("R10 tx only", d, 16'h000f);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule